// File: doc/BRIEF.md
# Byte-Lane SRAM Core With Mode Decode

This block is a word-organised static memory whose 16-bit words are split into a lower and an upper byte lane. A synchronous clock samples the control inputs each cycle, and a decoder turns them into one of several operating modes. These modes are standby, output-disabled, lower/upper/word read and lower/upper/word write. Each lane gates its own reads and writes. Separate input and output data buses are used, and a per-lane drive flag takes the place of tri-state pins. A power flag shows whether the part is active or in standby.

The memory is selected only when the active-low enable is low, the active-high select is high, and at least one lane enable is low. Depth is a parameter, so the array maps onto an on-chip RAM. A write stores data on the clock edge that samples it. Read data and the drive flags appear one cycle after the read condition is sampled.

Top module: `bytelane_sram`

## Requirements
- R1: When `en_a_n` is high, or `en_b` is low, or `hi_lane_n` and `lo_lane_n` are both high, the part is in standby: one cycle later `dout_drv` is 2'b00 and `power_on` is low, whatever the other inputs are.
- R2: A sampled read condition (selected, `wr_en_n` high, `out_en_n` low) sets `dout_drv[0]` exactly when `lo_lane_n` is low and `dout_drv[1]` exactly when `hi_lane_n` is low. The driven lanes of `dout` carry the stored bytes of the addressed word. Both appear one cycle after sampling.
- R3: A sampled write condition (selected, `wr_en_n` low) stores `din[7:0]` only if `lo_lane_n` is low and `din[15:8]` only if `hi_lane_n` is low. `out_en_n` has no effect on the write.
- R4: A lane that is not written keeps its previous contents, including during standby, output-disabled and read cycles and during writes to the other lane.
- R5: When the part is selected with `wr_en_n` high and `out_en_n` high, one cycle later `dout_drv` is 2'b00 and `power_on` is high.
- R6: While `wr_en_n` is low, `dout_drv` is 2'b00 one cycle later, even if `out_en_n` is low.
- R7: The lower lane (`lo_lane_n`, `dout_drv[0]`) maps to data bits 7:0, and the upper lane (`hi_lane_n`, `dout_drv[1]`) maps to bits 15:8, for both words and single bytes.
- R8: `power_on` is high one cycle after any sampled non-standby mode.
- R9: During reset, `dout`, `dout_drv` and `power_on` are all zero.
- R10: A lane of `dout` whose drive flag is low reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| addr | input | AW | Word address |
| din | input | 16 | Write data, lower lane in bits 7:0 |
| en_a_n | input | 1 | Active-low chip enable |
| en_b | input | 1 | Active-high chip select |
| out_en_n | input | 1 | Active-low output enable |
| wr_en_n | input | 1 | Active-low write enable |
| hi_lane_n | input | 1 | Active-low upper byte lane enable |
| lo_lane_n | input | 1 | Active-low lower byte lane enable |
| dout | output | 16 | Read data, zero in undriven lanes |
| dout_drv | output | 2 | Per-lane drive flag, bit 0 lower, bit 1 upper |
| power_on | output | 1 | High in any active mode, low in standby |

## Verification
A wrong decode shows on `dout_drv` and `power_on` on the very next clock edge after the control pattern is sampled, so each control combination is judged in the cycle after it is applied. A write that goes to the wrong lane, or a lane that is not held, leaves no mark until the word is read again. For that reason every applied pattern is followed at once by a word read of the same address, and this read exposes a corrupted byte within two cycles. The drive flags and the zeroing of undriven lanes separate a lane-mapping fault from a storage fault.

// File: rtl/bls_pkg.sv
package bls_pkg;

  localparam int NLANES = 2;

  typedef enum logic [2:0] {
    M_STANDBY,
    M_OUT_OFF,
    M_RD_LO,
    M_RD_HI,
    M_RD_WORD,
    M_WR_LO,
    M_WR_HI,
    M_WR_WORD
  } mode_e;

  // lane_n: bit 0 lower lane, bit 1 upper lane, active low
  function automatic mode_e decode_mode(input logic en_a_n, input logic en_b,
                                        input logic out_en_n, input logic wr_en_n,
                                        input logic [1:0] lane_n);
    mode_e m;
    if (en_a_n || !en_b || (&lane_n)) begin
      m = M_STANDBY;
    end else if (!wr_en_n) begin
      case (lane_n)
        2'b10:   m = M_WR_LO;
        2'b01:   m = M_WR_HI;
        default: m = M_WR_WORD;
      endcase
    end else if (out_en_n) begin
      m = M_OUT_OFF;
    end else begin
      case (lane_n)
        2'b10:   m = M_RD_LO;
        2'b01:   m = M_RD_HI;
        default: m = M_RD_WORD;
      endcase
    end
    return m;
  endfunction

  function automatic logic [1:0] lanes_written(input mode_e m);
    return {(m == M_WR_HI) || (m == M_WR_WORD), (m == M_WR_LO) || (m == M_WR_WORD)};
  endfunction

  function automatic logic [1:0] lanes_read(input mode_e m);
    return {(m == M_RD_HI) || (m == M_RD_WORD), (m == M_RD_LO) || (m == M_RD_WORD)};
  endfunction

endpackage

// File: rtl/bls_decode.sv
module bls_decode
  import bls_pkg::*;
(
  input  logic              en_a_n,
  input  logic              en_b,
  input  logic              out_en_n,
  input  logic              wr_en_n,
  input  logic [NLANES-1:0] lane_n,
  output logic [NLANES-1:0] lane_wr,
  output logic [NLANES-1:0] lane_rd,
  output logic              selected
);

  mode_e mode;

  always_comb begin
    mode     = decode_mode(en_a_n, en_b, out_en_n, wr_en_n, lane_n);
    lane_wr  = lanes_written(mode);
    lane_rd  = lanes_read(mode);
    selected = (mode != M_STANDBY);
  end

endmodule

// File: rtl/bls_lane.sv
module bls_lane #(
  parameter int DEPTH  = 1024,
  parameter int LANE_W = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [LANE_W-1:0] din,
  output logic [LANE_W-1:0] dout,
  output logic              drv
);

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      drv  <= 1'b0;
    end else begin
      drv  <= rd_en;
      dout <= rd_en ? mem[addr] : '0;
    end
  end

endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
  import bls_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int LANE_W = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            addr,
  input  logic [NLANES*LANE_W-1:0] din,
  input  logic                     en_a_n,
  input  logic                     en_b,
  input  logic                     out_en_n,
  input  logic                     wr_en_n,
  input  logic                     hi_lane_n,
  input  logic                     lo_lane_n,
  output logic [NLANES*LANE_W-1:0] dout,
  output logic [NLANES-1:0]        dout_drv,
  output logic                     power_on
);

  logic [NLANES-1:0] lane_n;
  logic [NLANES-1:0] lane_wr;
  logic [NLANES-1:0] lane_rd;
  logic              selected;

  assign lane_n = {hi_lane_n, lo_lane_n};

  bls_decode u_decode (
    .en_a_n   (en_a_n),
    .en_b     (en_b),
    .out_en_n (out_en_n),
    .wr_en_n  (wr_en_n),
    .lane_n   (lane_n),
    .lane_wr  (lane_wr),
    .lane_rd  (lane_rd),
    .selected (selected)
  );

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    bls_lane #(.DEPTH(DEPTH), .LANE_W(LANE_W), .AW(AW)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (addr),
      .wr_en (lane_wr[g]),
      .rd_en (lane_rd[g]),
      .din   (din[g*LANE_W +: LANE_W]),
      .dout  (dout[g*LANE_W +: LANE_W]),
      .drv   (dout_drv[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) power_on <= 1'b0;
    else        power_on <= selected;
  end

endmodule

// File: rtl/bls_checker.sv
module bls_checker #(
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en_a_n,
  input logic                en_b,
  input logic                out_en_n,
  input logic                wr_en_n,
  input logic                hi_lane_n,
  input logic                lo_lane_n,
  input logic [2*LANE_W-1:0] dout,
  input logic [1:0]          dout_drv,
  input logic                power_on,
  input logic [1:0]          lane_wr
);

  logic standby_in;
  assign standby_in = en_a_n || !en_b || (hi_lane_n && lo_lane_n);

  assert_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
    standby_in |=> (dout_drv == 2'b00) && !power_on);

  assert_read_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby_in && wr_en_n && !out_en_n) |=> dout_drv == ~$past({hi_lane_n, lo_lane_n}));

  assert_write_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_wr & {hi_lane_n, lo_lane_n}) == 2'b00);

  assert_no_write_in_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
    standby_in |-> lane_wr == 2'b00);

  assert_out_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby_in && wr_en_n && out_en_n) |=> (dout_drv == 2'b00) && power_on);

  assert_write_blocks_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_n |=> dout_drv == 2'b00);

  assert_active_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !standby_in |=> power_on);

  assert_idle_lo_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_drv[0] |-> dout[LANE_W-1:0] == '0);

  assert_idle_hi_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_drv[1] |-> dout[2*LANE_W-1:LANE_W] == '0);

endmodule

bind bytelane_sram bls_checker #(.LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_a_n    (en_a_n),
  .en_b      (en_b),
  .out_en_n  (out_en_n),
  .wr_en_n   (wr_en_n),
  .hi_lane_n (hi_lane_n),
  .lo_lane_n (lo_lane_n),
  .dout      (dout),
  .dout_drv  (dout_drv),
  .power_on  (power_on),
  .lane_wr   (lane_wr)
);

// File: tb/bytelane_sram_bench.sv
module bytelane_sram_bench;

  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] din = '0;
  logic        en_a_n = 1'b1, en_b = 1'b0, out_en_n = 1'b1, wr_en_n = 1'b1;
  logic        hi_lane_n = 1'b1, lo_lane_n = 1'b1;
  logic [15:0] dout;
  logic [1:0]  dout_drv;
  logic        power_on;

  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] refm [DEPTH];

  always #4 clk = ~clk;

  bytelane_sram #(.DEPTH(DEPTH), .LANE_W(8)) u_bytelane_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .en_a_n(en_a_n), .en_b(en_b), .out_en_n(out_en_n), .wr_en_n(wr_en_n),
    .hi_lane_n(hi_lane_n), .lo_lane_n(lo_lane_n),
    .dout(dout), .dout_drv(dout_drv), .power_on(power_on)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ctl bits: 5 en_a_n, 4 en_b, 3 wr_en_n, 2 out_en_n, 1 hi_lane_n, 0 lo_lane_n
  task automatic apply(input logic [5:0] ctl, input logic [AW-1:0] a, input logic [15:0] d);
    {en_a_n, en_b, wr_en_n, out_en_n, hi_lane_n, lo_lane_n} = ctl;
    addr = a;
    din  = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", {15'd0, power_on, dout_drv, dout}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", {15'd0, power_on, dout_drv, dout}, 32'd0);

    // fill every word with a word write
    for (int a = 0; a < DEPTH; a++) begin
      refm[a] = 16'(a * 16'h1357 ^ 16'hc0de);
      apply(6'b010100, AW'(a), refm[a]);
    end

    // sweep all 64 control patterns over several addresses
    for (int c = 0; c < 64; c++) begin
      for (int k = 0; k < 4; k++) begin
        logic [5:0] ctl = 6'(c);
        logic [AW-1:0] a = AW'((c * 5 + k * 3) % DEPTH);
        logic [15:0] d = 16'((c * 977 + k * 31) ^ 16'h5aa5);
        logic sel, rlo, rhi, wlo, whi;
        string tag;
        logic [15:0] exp_d;
        sel = !ctl[5] && ctl[4] && !(ctl[1] && ctl[0]);
        rlo = sel && ctl[3] && !ctl[2] && !ctl[0];
        rhi = sel && ctl[3] && !ctl[2] && !ctl[1];
        wlo = sel && !ctl[3] && !ctl[0];
        whi = sel && !ctl[3] && !ctl[1];
        exp_d = {rhi ? refm[a][15:8] : 8'h00, rlo ? refm[a][7:0] : 8'h00};
        apply(ctl, a, d);
        chk(sel ? "R8" : "R1", {31'd0, power_on}, {31'd0, sel});
        if (!sel)          tag = "R1";
        else if (!ctl[3])  tag = "R6";
        else if (ctl[2])   tag = "R5";
        else               tag = "R2";
        chk(tag, {30'd0, dout_drv}, {30'd0, rhi, rlo});
        if (rlo && rhi)      tag = "R7";
        else if (rlo || rhi) tag = "R2";
        else                 tag = "R10";
        chk(tag, {16'd0, dout}, {16'd0, exp_d});
        if (wlo) refm[a][7:0]  = d[7:0];
        if (whi) refm[a][15:8] = d[15:8];
        // word readback of the same address exposes stored lanes
        apply(6'b011000, a, ~d);
        chk((wlo || whi) ? "R3" : "R4", {14'd0, dout_drv, dout}, {14'd0, 2'b11, refm[a]});
      end
    end

    // final sweep: every word still holds its expected value (R4)
    for (int a = 0; a < DEPTH; a++) begin
      apply(6'b011000, AW'(a), 16'h0);
      chk("R4", {16'd0, dout}, {16'd0, refm[a]});
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule